// File: doc/BRIEF.md
# Indirect Redirection Table Controller

This block routes a set of I/O interrupt lines to interrupt messages. Software reaches all of its state through two 32-bit bus registers: a select register that holds an 8-bit internal index, and a data window that reads or writes the word at that index. The internal index space holds a writable controller ID word, a read-only version word that reports how many lines exist, and a table of two-word routing entries, one entry per input line.

Each routing entry carries a vector, a destination, a trigger-mode bit and a mask bit. When an unmasked line raises a request, the block presents that entry's vector and destination on a message port for one clock cycle. Requests from several lines are held pending and issued one per cycle, lowest line first. After reset every entry is masked, so software programs the table before it unmasks any line.

Top module: `irt_top`

## Requirements
- R1: A bus write at byte offset 0x00 loads the select index from data bits [7:0]; a read at offset 0x00 returns the index in bits [7:0] with zeros above. A read at any offset other than 0x00 and 0x10 returns zero, and a write there has no effect.
- R2: Window index 0x00 is the ID word: bits [31:24] are written and read back through offset 0x10, and bits [23:0] always read zero.
- R3: Window index 0x01 is the version word: bits [23:16] read NUM_LINES-1, bits [7:0] read 0x20, all other bits read zero, and writes to it are ignored.
- R4: Entry n sits at window index 0x10+2n (low word) and 0x10+2n+1 (high word). Low word: bits [7:0] vector, bit 15 trigger mode (1 = level, 0 = edge), bit 16 mask (1 = masked). High word: bits [31:24] destination. All other bits read zero.
- R5: After reset the select index and ID are zero, no message is presented, and every entry reads low word 0x00010000 (masked, edge mode, vector 0) and high word 0.
- R6: Window indices outside the ID, version and table ranges read zero and writes to them change nothing.
- R7: In edge mode, a rising edge on an unmasked line presents msgValid with that entry's vector and destination for exactly one cycle, in the cycle after the edge is sampled; holding the line high gives no further message.
- R8: A masked line produces no message, and an edge that arrives while the line is masked is not remembered when the line is later unmasked.
- R9: In level mode, a rising edge on an unmasked line produces a message, and unmasking a line that is already high produces one message in the cycle after the unmask write.
- R10: Requests from several lines in the same cycle are all delivered, one per cycle, lowest line number first.
- R11: Masking a line whose request is pending but not yet issued drops that request; no message for it appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe for the addressed bus register |
| busAddr | input | ADDR_W | Byte offset of the bus register (0x00 select, 0x10 window) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register, combinational |
| irqIn | input | NUM_LINES | Interrupt request lines, synchronous to clk |
| msgValid | output | 1 | A message is presented this cycle |
| msgVector | output | 8 | Vector of the presented message |
| msgDest | output | 8 | Destination of the presented message |

## Verification
The assertions assume that the request lines are already synchronous to the clock and that software never writes a mask bit in the same cycle that the affected line changes level, so each edge is judged against a settled mask. They also take the read data to be combinational on the current select and offset, and they track the select index from bus writes alone. The stimulus changes the lines and the bus only on falling edges. It separates each mask or unmask write from the line transitions by at least one clock, except in the one case that deliberately masks a line while its request waits behind another.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_TBL  = 8'h10;
  localparam logic [7:0] VER_CODE = 8'h20;

  typedef struct packed {
    logic        tblWr;
    logic        tblHi;
    logic [7:0]  entry;
    logic [31:0] wdata;
  } tblStrobe_t;
endpackage

// File: rtl/irt_ctrl.sv
module irt_ctrl
  import irt_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [31:0]       tblWord,
  output logic [31:0]       busRdata,
  output tblStrobe_t        stb
);
  localparam logic [8:0] TBL_END = 9'(int'(IDX_TBL) + 2 * NUM_LINES);
  localparam logic [7:0] MAX_IDX = 8'(NUM_LINES - 1);

  logic [7:0] selReg;
  logic [7:0] idReg;
  logic       isSel, isWin, inTbl;
  logic [7:0] offs;
  logic [31:0] winData;

  assign isSel = (busAddr == ADDR_W'(0));
  assign isWin = (busAddr == ADDR_W'(16));

  always_comb begin
    inTbl = (selReg >= IDX_TBL) && ({1'b0, selReg} < TBL_END);
    offs  = selReg - IDX_TBL;
    stb.tblWr = busWr && isWin && inTbl;
    stb.tblHi = offs[0];
    stb.entry = inTbl ? {1'b0, offs[7:1]} : 8'd0;
    stb.wdata = busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= 8'd0;
      idReg  <= 8'd0;
    end else begin
      if (busWr && isSel) selReg <= busWdata[7:0];
      if (busWr && isWin && selReg == IDX_ID) idReg <= busWdata[31:24];
    end
  end

  always_comb begin
    if (selReg == IDX_ID)       winData = {idReg, 24'd0};
    else if (selReg == IDX_VER) winData = {8'd0, MAX_IDX, 8'd0, VER_CODE};
    else if (inTbl)             winData = tblWord;
    else                        winData = 32'd0;
  end

  assign busRdata = isSel ? {24'd0, selReg} : (isWin ? winData : 32'd0);
endmodule

// File: rtl/irt_dp.sv
module irt_dp
  import irt_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tblStrobe_t           stb,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [31:0]          tblWord,
  output logic                 msgValid,
  output logic [7:0]           msgVector,
  output logic [7:0]           msgDest
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [7:0] vecTbl  [NUM_LINES];
  logic [7:0] destTbl [NUM_LINES];
  logic [NUM_LINES-1:0] levelVec, maskVec, maskPrev, irqPrev;
  logic [NUM_LINES-1:0] pending, trig, eligible, grantVec;
  logic [IDX_W-1:0] selIdx, grantIdx;

  assign selIdx = stb.entry[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        vecTbl[i]  <= 8'd0;
        destTbl[i] <= 8'd0;
      end
      levelVec <= '0;
      maskVec  <= '1;
    end else if (stb.tblWr) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (selIdx == IDX_W'(i)) begin
          if (stb.tblHi) begin
            destTbl[i] <= stb.wdata[31:24];
          end else begin
            vecTbl[i]   <= stb.wdata[7:0];
            levelVec[i] <= stb.wdata[15];
            maskVec[i]  <= stb.wdata[16];
          end
        end
      end
    end
  end

  always_comb begin
    trig = ~maskVec & ((irqIn & ~irqPrev) | (levelVec & irqIn & maskPrev));
    eligible = pending & ~maskVec;
    grantVec = eligible & ~(eligible - 1'b1);
    grantIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) grantIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev  <= '0;
      maskPrev <= '1;
      pending  <= '0;
    end else begin
      irqPrev  <= irqIn;
      maskPrev <= maskVec;
      pending  <= ((pending & ~grantVec) | trig) & ~maskVec;
    end
  end

  assign msgValid  = |eligible;
  assign msgVector = vecTbl[grantIdx];
  assign msgDest   = destTbl[grantIdx];

  assign tblWord = stb.tblHi ? {destTbl[selIdx], 24'd0}
                             : {15'd0, maskVec[selIdx], levelVec[selIdx], 7'd0, vecTbl[selIdx]};
endmodule

// File: rtl/irt_top.sv
module irt_top
  import irt_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 msgValid,
  output logic [7:0]           msgVector,
  output logic [7:0]           msgDest
);
  tblStrobe_t  stb;
  logic [31:0] tblWord;

  irt_ctrl #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .tblWord(tblWord), .busRdata(busRdata), .stb(stb)
  );

  irt_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .irqIn(irqIn), .tblWord(tblWord),
    .msgValid(msgValid), .msgVector(msgVector), .msgDest(msgDest)
  );
endmodule

// File: rtl/irt_chk.sv
module irt_chk #(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              msgValid,
  input logic [7:0]        msgVector,
  input logic [7:0]        msgDest
);
  localparam logic [7:0] TBL_END = 8'(16 + 2 * NUM_LINES);
  logic [7:0] shadowSel;
  logic       atWin, atSel;

  assign atWin = (busAddr == ADDR_W'(16));
  assign atSel = (busAddr == ADDR_W'(0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowSel <= 8'd0;
    else if (busWr && atSel) shadowSel <= busWdata[7:0];
  end

  assert_sel_readback_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && atSel) |=> (!atSel || busRdata == {24'd0, $past(busWdata[7:0])}));

  assert_other_offset_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!atSel && !atWin) |-> (busRdata == 32'd0));

  assert_id_low_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (atWin && shadowSel == 8'h00) |-> (busRdata[23:0] == 24'd0));

  assert_version_field_R3: assert property (@(posedge clk) disable iff (!rstN)
    (atWin && shadowSel == 8'h01) |-> (busRdata[23:16] == 8'(NUM_LINES - 1)));

  assert_entry_reserved_R4: assert property (@(posedge clk) disable iff (!rstN)
    (atWin && shadowSel >= 8'h10 && shadowSel < TBL_END) |->
      (shadowSel[0] ? (busRdata[23:0] == 24'd0)
                    : (busRdata[31:17] == 15'd0 && busRdata[14:8] == 7'd0)));

  assert_msg_known_R7: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !$isunknown({msgVector, msgDest}));
endmodule

bind irt_top irt_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .msgValid(msgValid), .msgVector(msgVector), .msgDest(msgDest)
);

// File: tb/irt_top_tb.sv
module irt_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] irqIn = '0;
  logic msgValid;
  logic [7:0] msgVector, msgDest;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irt_top #(.NUM_LINES(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqIn(irqIn), .msgValid(msgValid),
    .msgVector(msgVector), .msgDest(msgDest)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic winWr(input logic [7:0] idx, input logic [31:0] d);
    wr(AW'(0), {24'd0, idx});
    wr(AW'(16), d);
  endtask

  task automatic winRd(input logic [7:0] idx, output logic [31:0] d);
    wr(AW'(0), {24'd0, idx});
    @(negedge clk);
    busAddr = AW'(16);
    #1 d = busRdata;
  endtask

  task automatic expectMsg(input string tag, input logic [7:0] v, input logic [7:0] dst);
    expQ.push_back({v, dst});
    tagQ.push_back(tag);
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    chk({tag, " queue drained"}, expQ.size(), 0);
  endtask

  // monitor: compare every presented message against the scoreboard
  always @(negedge clk) begin
    if (rstN && msgValid && !finished) begin
      if (expQ.size() == 0) begin
        chk("R8/R11 unexpected message", {16'd0, msgVector, msgDest}, 32'hFFFFFFFF);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {16'd0, msgVector, msgDest}, {16'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R5 reset state
    chk("R5 msgValid", {31'd0, msgValid}, 0);
    busAddr = AW'(0); #1 chk("R5 select", busRdata, 0);
    winRd(8'h00, d); chk("R5 id", d, 0);
    winRd(8'h1A, d); chk("R5 entry5 low", d, 32'h00010000);
    winRd(8'h1B, d); chk("R5 entry5 high", d, 0);

    // R1 select register and other offsets
    wr(AW'(0), 32'hFFFFFF2A);
    busAddr = AW'(0); #1 chk("R1 select readback", busRdata, 32'h2A);
    wr(AW'(8), 32'hFFFFFFFF);
    busAddr = AW'(8); #1 chk("R1 other offset", busRdata, 0);
    busAddr = AW'(0); #1 chk("R1 select after stray write", busRdata, 32'h2A);

    // R3 version, read-only
    winRd(8'h01, d); chk("R3 version", d, 32'h00170020);
    winWr(8'h01, 32'hFFFFFFFF);
    winRd(8'h01, d); chk("R3 version after write", d, 32'h00170020);

    // R2 ID
    winWr(8'h00, 32'hA5FFFFFF);
    winRd(8'h00, d); chk("R2 id", d, 32'hA5000000);

    // R6 unimplemented indices
    winWr(8'h02, 32'hFFFFFFFF);
    winRd(8'h02, d); chk("R6 index 2", d, 0);
    winWr(8'h40, 32'hFFFFFFFF);
    winRd(8'h40, d); chk("R6 index past table", d, 0);
    winRd(8'h00, d); chk("R6 id untouched", d, 32'hA5000000);

    // R4 entry layout (entry 3)
    winWr(8'h16, 32'hFFFE7F41);
    winRd(8'h16, d); chk("R4 entry3 low", d, 32'h00000041);
    winWr(8'h17, 32'h05FFFFFF);
    winRd(8'h17, d); chk("R4 entry3 high", d, 32'h05000000);

    // R7 edge message
    expectMsg("R7 edge msg", 8'h41, 8'h05);
    @(negedge clk); irqIn[3] = 1'b1;
    repeat (5) @(negedge clk); irqIn[3] = 1'b0;
    drain("R7");

    // R8 masked line, edge not remembered
    winWr(8'h1E, 32'h00010077);
    winWr(8'h1F, 32'h02000000);
    @(negedge clk); irqIn[7] = 1'b1;
    @(negedge clk); irqIn[7] = 1'b0;
    @(negedge clk); irqIn[7] = 1'b1;
    winWr(8'h1E, 32'h00000077);
    drain("R8 no replay");
    expectMsg("R8 after unmask", 8'h77, 8'h02);
    @(negedge clk); irqIn[7] = 1'b0;
    @(negedge clk); irqIn[7] = 1'b1;
    @(negedge clk); irqIn[7] = 1'b0;
    drain("R8");

    // R9 level mode
    winWr(8'h22, 32'h00018099);
    winWr(8'h23, 32'h09000000);
    @(negedge clk); irqIn[9] = 1'b1;
    repeat (2) @(negedge clk);
    expectMsg("R9 unmask while high", 8'h99, 8'h09);
    winWr(8'h22, 32'h00008099);
    drain("R9 unmask");
    @(negedge clk); irqIn[9] = 1'b0;
    expectMsg("R9 level rise", 8'h99, 8'h09);
    @(negedge clk); irqIn[9] = 1'b1;
    @(negedge clk); irqIn[9] = 1'b0;
    drain("R9");

    // R10 simultaneous requests, lowest first
    winWr(8'h14, 32'h00000022); winWr(8'h15, 32'h12000000);
    winWr(8'h1A, 32'h00000055); winWr(8'h1B, 32'h15000000);
    expectMsg("R10 first line2", 8'h22, 8'h12);
    expectMsg("R10 second line5", 8'h55, 8'h15);
    @(negedge clk); irqIn[2] = 1'b1; irqIn[5] = 1'b1;
    repeat (3) @(negedge clk); irqIn[2] = 1'b0; irqIn[5] = 1'b0;
    drain("R10");

    // R11 mask while pending
    winWr(8'h18, 32'h00000044); winWr(8'h19, 32'h14000000);
    winWr(8'h20, 32'h00000088); winWr(8'h21, 32'h18000000);
    wr(AW'(0), 32'h20);
    expectMsg("R11 surviving line4", 8'h44, 8'h14);
    @(negedge clk); irqIn[4] = 1'b1; irqIn[8] = 1'b1;
    @(negedge clk);
    busAddr = AW'(16); busWdata = 32'h00010088; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    repeat (3) @(negedge clk); irqIn[4] = 1'b0; irqIn[8] = 1'b0;
    drain("R11");
    winRd(8'h20, d); chk("R11 entry8 masked", d, 32'h00010088);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule